// File: doc/BRIEF.md
# Gated Binary Seconds Counter

This block keeps a 32-bit binary count of elapsed seconds. A slow clock-enable input, nominally pulsing at 32.768 kHz, feeds a prescaler that issues one tick per `PRESC_DIV` enable pulses. Each tick advances the count by one. The count wraps at 32 bits. Software turns the raw seconds value into time of day and calendar date.

A small register bus gives access to the count as four bytes. The byte at address 0 is the least significant. Bytes written over the bus land in a staging register, and a separate commit strobe moves all 32 staged bits into the count at once. Reading byte 0 captures the whole count into a snapshot, so a read of bytes 0 to 3 returns one coherent value even when a tick arrives partway through. A halt bit in a control register stops the count from advancing. When the system also runs from its backup supply, that same bit stops the oscillator, and the `osc_run` output reports this.

Top module: `secs_counter_top`

## Requirements
- R1: The count increases by exactly one on every `PRESC_DIV`-th cycle in which `osc_ce` is high while the oscillator runs. Cycles with `osc_ce` low have no effect. The new count is visible on `count_value` right after the clock edge that samples the last enable pulse.
- R2: From 32'hFFFF_FFFF the next tick gives 32'h0000_0000.
- R3: A bus write to address 0, 1, 2 or 3 sets staging bits [7:0], [15:8], [23:16] or [31:24] respectively. The count does not change until a commit.
- R4: A `commit` pulse loads the staged 32-bit value into the count at that clock edge. It also clears the prescaler, so the next tick needs a full `PRESC_DIV` enable pulses.
- R5: The control register sits at address 4, and bit 7 of it is the halt bit. While halt is 1 on main power (`on_backup` low), the count stays frozen. The prescaler keeps dividing, and `osc_run` stays 1.
- R6: While halt is 1 and `on_backup` is 1, `osc_run` is 0 and the prescaler holds its position. No enable pulse is counted.
- R7: `rd_data` takes the selected byte at the edge that samples `rd_en` and holds it until the next read. A read of address 0 returns live count bits [7:0] and captures all 32 bits. Reads of addresses 1, 2 and 3 return bits [15:8], [23:16] and [31:24] of that capture.
- R8: Control bits 6 to 0 read as 0. Addresses 5 to 7 read as 8'h00 and ignore writes. After reset the count, staging, snapshot, halt bit and `rd_data` are all 0, and `osc_run` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_ce | input | 1 | One-cycle enable pulse per time-base period (32.768 kHz nominal) |
| on_backup | input | 1 | High while the system runs from its backup supply |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| commit | input | 1 | Loads the staged value into the count and clears the prescaler |
| rd_data | output | 8 | Registered read data |
| count_value | output | 32 | Live seconds count |
| osc_run | output | 1 | High while the oscillator runs |

## Verification
A counted enable pulse, a commit, and a write to the halt bit each take effect at the same rising edge that samples them. The bench therefore drives every input on a falling edge and checks `count_value` and `osc_run` on the next falling edge. Read data is also registered at the sampling edge, so each read check samples `rd_data` one falling edge after `rd_en` was raised. Tick tests count enable pulses one at a time: they check that the count is unchanged after `PRESC_DIV`-1 pulses and has changed after the last one. This pins the divide ratio exactly, and it pins the prescaler clear on commit and the prescaler hold during a backup stop.

// File: rtl/secs_counter_pkg.sv
package secs_counter_pkg;
  localparam int unsigned SC_BYTES  = 4;
  localparam int unsigned SC_CNT_W  = SC_BYTES * 8;
  localparam int unsigned SC_ADDR_W = 3;
  localparam logic [SC_ADDR_W-1:0] SC_ADDR_CTRL = 3'd4;
  localparam int unsigned SC_HALT_BIT = 7;
endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler #(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ce,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PRE_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             step;

  always_comb begin
    step  = osc_ce & run;
    tick  = step & (pre_q == PRE_LAST);
    pre_d = pre_q;
    if (clr)
      pre_d = '0;
    else if (tick)
      pre_d = '0;
    else if (step)
      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R1: the divider never leaves its range
  p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);
  // R6: a stopped oscillator holds the divider position
  p_pre_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));
  // R4: commit restarts the divider
  p_pre_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/secs_count_core.sv
module secs_count_core
  import secs_counter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SC_BYTES-1:0] stg_we,
  input  logic [7:0]          wr_data,
  input  logic                commit,
  input  logic                tick,
  input  logic                halt,
  output logic [SC_CNT_W-1:0] count
);
  logic [SC_CNT_W-1:0] stg_q, stg_d;
  logic [SC_CNT_W-1:0] cnt_q, cnt_d;
  logic                adv;

  for (genvar b = 0; b < SC_BYTES; b++) begin : g_stage
    always_comb begin
      stg_d[b*8 +: 8] = stg_q[b*8 +: 8];
      if (stg_we[b]) stg_d[b*8 +: 8] = wr_data;
    end
  end

  always_comb begin
    adv   = tick & ~halt;
    cnt_d = cnt_q;
    if (commit)   cnt_d = stg_q;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else begin
      stg_q <= stg_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R1, R2: one tick moves the count by one, modulo 2^32
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !commit) |=> (cnt_q == $past(cnt_q) + 32'd1));
  // R5: halt freezes the count
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !commit) |=> $stable(cnt_q));
  // R4: commit moves the staged word into the count
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == $past(stg_q)));
  // R3: without commit or tick the count is untouched by byte writes
  p_stage_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/secs_reg_port.sv
module secs_reg_port
  import secs_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [SC_ADDR_W-1:0] addr,
  input  logic [7:0]           wr_data,
  input  logic [SC_CNT_W-1:0]  count,
  output logic [SC_BYTES-1:0]  stg_we,
  output logic                 halt,
  output logic [7:0]           rd_data
);
  logic                halt_q, halt_d;
  logic [SC_CNT_W-1:0] snap_q, snap_d;
  logic [7:0]          rd_q, rd_d, rd_sel;

  for (genvar b = 0; b < SC_BYTES; b++) begin : g_we
    assign stg_we[b] = wr_en & (addr == SC_ADDR_W'(b));
  end

  always_comb begin
    rd_sel = 8'h00;
    if (addr == SC_ADDR_CTRL)
      rd_sel = {halt_q, 7'b0};
    else if (addr == '0)
      rd_sel = count[7:0];
    else
      for (int i = 1; i < SC_BYTES; i++)
        if (addr == SC_ADDR_W'(i)) rd_sel = snap_q[i*8 +: 8];
  end

  always_comb begin
    halt_d = halt_q;
    if (wr_en && addr == SC_ADDR_CTRL) halt_d = wr_data[SC_HALT_BIT];
    snap_d = snap_q;
    if (rd_en && addr == '0) snap_d = count;
    rd_d = rd_q;
    if (rd_en) rd_d = rd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      snap_q <= '0;
      rd_q   <= '0;
    end else begin
      halt_q <= halt_d;
      snap_q <= snap_d;
      rd_q   <= rd_d;
    end
  end

  assign halt    = halt_q;
  assign rd_data = rd_q;

  // R8: control padding bits read as zero
  p_ctrl_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SC_ADDR_CTRL) |=> (rd_q[6:0] == 7'd0));
  // R7: read data holds between reads
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
  // R7: snapshot only moves on a read of byte zero
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == '0) |=> $stable(snap_q));
endmodule

// File: rtl/secs_counter_top.sv
module secs_counter_top
  import secs_counter_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_ce,
  input  logic        on_backup,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wr_data,
  input  logic        commit,
  output logic [7:0]  rd_data,
  output logic [31:0] count_value,
  output logic        osc_run
);
  logic [1:0]          rst_sync_q;
  logic                rst_n_s;
  logic                halt;
  logic                tick;
  logic [SC_BYTES-1:0] stg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign osc_run = ~(halt & on_backup);

  secs_prescaler #(.PRESC_DIV(PRESC_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .osc_ce (osc_ce),
    .run    (osc_run),
    .clr    (commit),
    .tick   (tick)
  );

  secs_count_core u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stg_we  (stg_we),
    .wr_data (wr_data),
    .commit  (commit),
    .tick    (tick),
    .halt    (halt),
    .count   (count_value)
  );

  secs_reg_port u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .count   (count_value),
    .stg_we  (stg_we),
    .halt    (halt),
    .rd_data (rd_data)
  );

  // R6: oscillator stops only for halt on backup supply
  p_osc_stop_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halt && on_backup) |-> !osc_run);
  // R5: on main power the oscillator always runs
  p_osc_main_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !on_backup |-> osc_run);
endmodule

// File: tb/secs_counter_top_bench.sv
module secs_counter_top_bench;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_ce = 1'b0;
  logic        on_backup = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        commit = 1'b0;
  logic [7:0]  rd_data;
  logic [31:0] count_value;
  logic        osc_run;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secs_counter_top #(.PRESC_DIV(DIV)) u_secs_counter_top (
    .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce), .on_backup(on_backup),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .commit(commit), .rd_data(rd_data), .count_value(count_value),
    .osc_run(osc_run)
  );

  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'h1234_5678, 32'hA5C3_0F81, 32'hFFFF_FFFF, 32'h8000_0001
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    for (int b = 0; b < 4; b++) bus_wr(3'(b), v[b*8 +: 8]);
    do_commit();
  endtask

  task automatic pulses(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      osc_ce = 1'b1;
      @(negedge clk);
      osc_ce = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  rb;
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state
    check("R8 reset count", count_value, 32'd0);
    check("R8 reset osc_run", {31'd0, osc_run}, 32'd1);
    check("R8 reset rd_data", {24'd0, rd_data}, 32'd0);
    bus_rd(3'd4, rb);
    check("R8 reset ctrl", {24'd0, rb}, 32'd0);

    // R3 R4 R7: vector table of load, commit, read back
    prev = 32'd0;
    for (int i = 0; i < NV; i++) begin
      for (int b = 0; b < 4; b++) bus_wr(3'(b), VEC[i][b*8 +: 8]);
      check("R3 staged not live", count_value, prev);
      do_commit();
      check("R4 commit value", count_value, VEC[i]);
      for (int b = 0; b < 4; b++) begin
        bus_rd(3'(b), rb);
        check("R7 byte readback", {24'd0, rb}, {24'd0, VEC[i][b*8 +: 8]});
      end
      prev = VEC[i];
    end

    // R1: divide ratio with varied gaps
    load(32'd0);
    pulses(1, 0); pulses(1, 3); pulses(1, 1);
    check("R1 before last pulse", count_value, 32'd0);
    pulses(1, 0);
    check("R1 tick", count_value, 32'd1);
    repeat (5) @(negedge clk);
    check("R1 idle no change", count_value, 32'd1);
    pulses(DIV, 1);
    check("R1 second tick", count_value, 32'd2);

    // R2: wrap
    load(32'hFFFF_FFFF);
    pulses(DIV, 0);
    check("R2 wrap", count_value, 32'd0);

    // R7: snapshot coherence
    load(32'h00FF_FFFF);
    bus_rd(3'd0, rb);
    check("R7 byte0 live", {24'd0, rb}, 32'hFF);
    pulses(DIV, 0);
    check("R7 live moved", count_value, 32'h0100_0000);
    bus_rd(3'd1, rb); check("R7 snap byte1", {24'd0, rb}, 32'hFF);
    bus_rd(3'd2, rb); check("R7 snap byte2", {24'd0, rb}, 32'hFF);
    bus_rd(3'd3, rb); check("R7 snap byte3", {24'd0, rb}, 32'h00);

    // R5: halt on main power freezes count, divider keeps running
    load(32'd16);
    bus_wr(3'd4, 8'h80);
    check("R5 osc_run main", {31'd0, osc_run}, 32'd1);
    pulses(2, 0);
    check("R5 frozen", count_value, 32'd16);
    bus_wr(3'd4, 8'h00);
    pulses(2, 0);
    check("R5 divider kept running", count_value, 32'd17);

    // R6: halt on backup stops oscillator and holds divider
    load(32'd32);
    on_backup = 1'b1;
    bus_wr(3'd4, 8'h80);
    check("R6 osc stopped", {31'd0, osc_run}, 32'd0);
    pulses(3, 0);
    bus_wr(3'd4, 8'h00);
    check("R6 osc restarted", {31'd0, osc_run}, 32'd1);
    pulses(3, 0);
    check("R6 divider held", count_value, 32'd32);
    pulses(1, 0);
    check("R6 tick after hold", count_value, 32'd33);
    on_backup = 1'b0;

    // R4: commit clears the divider
    load(32'd48);
    pulses(2, 0);
    do_commit();
    pulses(DIV - 1, 0);
    check("R4 divider cleared", count_value, 32'd48);
    pulses(1, 0);
    check("R4 tick after clear", count_value, 32'd49);

    // R8: control padding and unused addresses
    bus_wr(3'd4, 8'hFF);
    bus_rd(3'd4, rb);
    check("R8 ctrl pad", {24'd0, rb}, 32'h80);
    bus_wr(3'd4, 8'h7F);
    bus_rd(3'd4, rb);
    check("R8 ctrl low bits ignored", {24'd0, rb}, 32'h00);
    prev = count_value;
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd7, 8'h55);
    do_commit();
    check("R8 unused write no stage", count_value, 32'd48);
    bus_rd(3'd5, rb);
    check("R8 addr5 zero", {24'd0, rb}, 32'd0);
    bus_rd(3'd7, rb);
    check("R8 addr7 zero", {24'd0, rb}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule